// File: doc/BRIEF.md
# Two-Wire Slave with a 16-bit Register Bank

This block is a slave on a two-wire serial bus (a clock line and an open-drain data line). It holds a bank of 16-bit registers selected by an 8-bit register pointer. A bus master writes a device address, then a register pointer, then any number of data bytes. The bytes are taken in pairs and each pair fills one register. To read, the master sets the pointer with a write and then issues a repeated start with the read form of the device address. The slave then streams register contents two bytes per register.

Two strap inputs choose which of four device addresses the slave answers to. Both bus lines are resynchronised and oversampled by the system clock, and all protocol decisions come from edges seen in that clock domain. The slave never drives the data line high. It only asserts an output enable that pulls the line low, for acknowledges and for zero bits of read data.

Top module: `twowire_reg16_slave`

## Requirements
- R1: A start condition (data falling while the clock is high) restarts address reception from any state. A stop condition (data rising while the clock is high) returns the slave to idle with the data line released.
- R2: The first byte after a start is compared with the strapped address: sel 00 gives 0x90, 01 gives 0x98, 10 gives 0xB0 and 11 gives 0xB8 (sel[1] adds 0x20, sel[0] adds 0x08). Bit 0 is the direction, 0 for write and 1 for read. On a mismatch the slave gives no acknowledge and ignores the bus until the next start.
- R3: After a matching address byte, after the register-pointer byte and after every write data byte, the slave pulls the data line low for the ninth clock pulse. It releases the line once that clock falls.
- R4: In a write, the byte after the address loads the register pointer. Data bytes then arrive high byte first, and the register takes {high, low} only when the low byte completes.
- R5: After each complete 16-bit write the pointer advances by one, wrapping from 0xFF to 0x00.
- R6: If a start or stop follows a lone high byte, the register stays unchanged and the next data byte counts as a new high byte.
- R7: In a read (address bit 0 = 1 after a repeated start), the slave sends the register at the pointer high byte first, MSB first. It changes the data line only while the clock is low.
- R8: During a read, the pointer advances after each low byte and a master acknowledge continues the stream. A master NACK makes the slave release the line and stay silent until the next start.
- R9: After reset the data line is released and the slave is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_sel | input | 2 | Strap pins choosing one of four device addresses |
| sda_oe | output | 1 | Registered pull-down enable for the data line (1 = drive low) |

## Verification
The assertions check on every cycle that the pull-down enable changes only while the synchronised clock is low, except when a start or stop forces it off. They also check that a start re-arms address reception, that a stop leaves the slave idle with no pending half-word, that the enable is never asserted in idle, and that every register write advances the pointer by one. Only the bench scenarios can show the data path end to end: address matching for each strap setting, written words read back in the right byte order, pointer wrap, a discarded lone high byte, and silence after a NACK.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_REG,
    PH_WR,
    PH_RD
  } phase_t;

  // write form of the device address chosen by the strap pins
  function automatic logic [7:0] dev_addr(input logic [1:0] sel);
    return 8'h90 | {2'b00, sel[1], 1'b0, sel[0], 3'b000};
  endfunction
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rose,
  output logic fell
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      last  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rose  = chain[STAGES-1] & ~last;
  assign fell  = ~chain[STAGES-1] & last;
endmodule

// File: rtl/tw_regbank.sv
module tw_regbank #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/twowire_reg16_slave.sv
module twowire_reg16_slave #(
  parameter int REG_AW      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_sel,
  output logic       sda_oe
);
  import tw_pkg::*;

  localparam int BW = 8;
  localparam int DW = 2 * BW;
  localparam logic [3:0] ACK_BIT = 4'(BW);
  localparam logic [3:0] ACK_END = 4'(BW + 1);

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst(rst), .din(scl_i),
    .level(scl_lvl), .rose(scl_rise), .fell(scl_fall)
  );

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst(rst), .din(sda_i),
    .level(sda_lvl), .rose(sda_rise), .fell(sda_fall)
  );

  logic start_ev, stop_ev;
  assign start_ev = sda_fall & scl_lvl & ~scl_rise;
  assign stop_ev  = sda_rise & scl_lvl & ~scl_rise;

  phase_t            ph;
  logic [3:0]        cnt;
  logic [BW-1:0]     sh, tx, hi_q;
  logic              rd_mode, hi_pend, lo_side, nack_q;
  logic [REG_AW-1:0] ptr, wa_q;
  logic              we_q;
  logic [DW-1:0]     wd_q, rdata;
  logic [BW-1:0]     next_byte;
  logic [7:0]        own_addr;
  logic              dev_hit;

  assign own_addr  = dev_addr(addr_sel);
  assign dev_hit   = (sh[7:1] == own_addr[7:1]);
  assign next_byte = lo_side ? rdata[BW-1:0] : rdata[DW-1:BW];

  tw_regbank #(.AW(REG_AW), .DW(DW)) u_bank (
    .clk(clk), .we(we_q), .waddr(wa_q), .wdata(wd_q),
    .raddr(ptr), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      hi_q    <= '0;
      rd_mode <= 1'b0;
      hi_pend <= 1'b0;
      lo_side <= 1'b0;
      nack_q  <= 1'b0;
      ptr     <= '0;
      wa_q    <= '0;
      wd_q    <= '0;
      we_q    <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (start_ev) begin
        ph      <= PH_DEV;
        cnt     <= '0;
        sda_oe  <= 1'b0;
        hi_pend <= 1'b0;
        lo_side <= 1'b0;
      end else if (stop_ev) begin
        ph      <= PH_IDLE;
        cnt     <= '0;
        sda_oe  <= 1'b0;
        hi_pend <= 1'b0;
      end else if (ph != PH_IDLE) begin
        if (scl_rise) begin
          if (cnt < ACK_BIT) begin
            sh  <= {sh[BW-2:0], sda_lvl};
            cnt <= cnt + 4'd1;
          end else if (cnt == ACK_BIT) begin
            nack_q <= sda_lvl;
            cnt    <= ACK_END;
          end
        end else if (scl_fall) begin
          if (cnt == ACK_BIT) begin
            case (ph)
              PH_DEV: begin
                if (dev_hit) begin
                  sda_oe  <= 1'b1;
                  rd_mode <= sh[0];
                end else begin
                  ph <= PH_IDLE;
                end
              end
              PH_REG: begin
                sda_oe  <= 1'b1;
                ptr     <= sh[REG_AW-1:0];
                hi_pend <= 1'b0;
                lo_side <= 1'b0;
              end
              PH_WR: begin
                sda_oe <= 1'b1;
                if (hi_pend) begin
                  we_q    <= 1'b1;
                  wa_q    <= ptr;
                  wd_q    <= {hi_q, sh};
                  ptr     <= ptr + 1'b1;
                  hi_pend <= 1'b0;
                end else begin
                  hi_q    <= sh;
                  hi_pend <= 1'b1;
                end
              end
              PH_RD: begin
                sda_oe  <= 1'b0;
                lo_side <= ~lo_side;
                if (lo_side) ptr <= ptr + 1'b1;
              end
              default: ;
            endcase
          end else if (cnt == ACK_END) begin
            cnt <= '0;
            case (ph)
              PH_DEV: begin
                if (rd_mode) begin
                  ph     <= PH_RD;
                  tx     <= next_byte;
                  sda_oe <= ~next_byte[BW-1];
                end else begin
                  ph     <= PH_REG;
                  sda_oe <= 1'b0;
                end
              end
              PH_REG: begin
                ph     <= PH_WR;
                sda_oe <= 1'b0;
              end
              PH_WR: sda_oe <= 1'b0;
              PH_RD: begin
                if (nack_q) begin
                  ph     <= PH_IDLE;
                  sda_oe <= 1'b0;
                end else begin
                  tx     <= next_byte;
                  sda_oe <= ~next_byte[BW-1];
                end
              end
              default: ;
            endcase
          end else if (ph == PH_RD) begin
            sda_oe <= ~tx[3'(4'd7 - cnt)];
          end
        end
      end
    end
  end

  AST_START_ARMS: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (ph == PH_DEV && cnt == 4'd0 && !sda_oe)); // R1

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> (ph == PH_IDLE && !sda_oe && !hi_pend)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_IDLE) |-> !sda_oe); // R8

  AST_ACK_SLOT: assert property (@(posedge clk) disable iff (rst)
    (sda_oe && (ph == PH_DEV || ph == PH_REG || ph == PH_WR))
      |-> (cnt == ACK_BIT || cnt == ACK_END)); // R3

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe) && !$past(start_ev || stop_ev)) |-> !scl_lvl); // R7

  AST_WRITE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    we_q |-> (ptr == REG_AW'(wa_q + 1'b1))); // R5

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= ACK_END); // R3
endmodule

// File: tb/twowire_reg16_slave_test.sv
module twowire_reg16_slave_test;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [1:0] sel = 2'b00;
  logic       sda_oe;
  logic       sda_line;
  logic       done = 1'b0;
  int         n_chk = 0;
  int         n_err = 0;

  assign sda_line = m_sda & ~sda_oe;

  always #10 clk = ~clk;

  twowire_reg16_slave uut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .addr_sel(sel), .sda_oe(sda_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq();
    scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic bus_bit(input logic b, output logic seen);
    m_sda = b; wq();
    scl = 1'b1; wq();
    seen = sda_line; wq();
    scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] d, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], s);
    bus_bit(1'b1, s);
    acked = (s == 1'b0);
    m_sda = 1'b1;
  endtask

  task automatic recv_byte(input bit give_nack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      d[i] = s;
    end
    bus_bit(give_nack, s);
    m_sda = 1'b1;
  endtask

  task automatic write_word(input logic [7:0] dev, input logic [7:0] ra, input logic [15:0] w);
    bit a;
    bus_start();
    send_byte(dev, a); check(a, "R3 dev ack", a, 1);
    send_byte(ra, a);  check(a, "R3 reg ack", a, 1);
    send_byte(w[15:8], a); check(a, "R3 data ack", a, 1);
    send_byte(w[7:0], a);  check(a, "R3 data ack", a, 1);
    bus_stop();
  endtask

  task automatic read_word(input logic [7:0] ra, input logic [15:0] exp, input string req);
    bit a;
    logic [7:0] h, l;
    bus_start();
    send_byte(8'h90, a);
    send_byte(ra, a);
    bus_start();
    send_byte(8'h91, a); check(a, "R7 read addr ack", a, 1);
    recv_byte(1'b0, h);
    recv_byte(1'b1, l);
    bus_stop();
    check({h, l} === exp, req, {h, l}, exp);
  endtask

  task automatic t_reset();
    check(sda_oe === 1'b0, "R9 released after reset", sda_oe, 0);
    check(sda_line === 1'b1, "R9 line high", sda_line, 1);
  endtask

  task automatic t_addr_select();
    bit a;
    logic [7:0] addrs [4] = '{8'h90, 8'h98, 8'hB0, 8'hB8};
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      for (int k = 0; k < 4; k++) begin
        bus_start();
        send_byte(addrs[k], a);
        bus_stop();
        if (k == s) check(a, "R2 strap match ack", a, 1);
        else        check(!a, "R2 mismatch no ack", a, 0);
      end
    end
    sel = 2'b00;
    bus_start();
    send_byte(8'h98, a);
    send_byte(8'h00, a);
    check(!a, "R2 ignored after mismatch", a, 0);
    bus_stop();
  endtask

  task automatic t_write_read();
    bit a;
    logic [7:0] d [4];
    logic [7:0] exp [4] = '{8'h12, 8'h34, 8'h56, 8'h78};
    bus_start();
    send_byte(8'h90, a); check(a, "R3 dev ack", a, 1);
    send_byte(8'h10, a); check(a, "R4 reg ack", a, 1);
    for (int i = 0; i < 4; i++) begin
      send_byte(exp[i], a); check(a, "R3 data ack", a, 1);
    end
    bus_stop();
    bus_start();
    send_byte(8'h90, a);
    send_byte(8'h10, a);
    bus_start();
    send_byte(8'h91, a); check(a, "R7 read addr ack", a, 1);
    for (int i = 0; i < 4; i++) recv_byte(i == 3, d[i]);
    check(sda_oe === 1'b0, "R8 released after nack", sda_oe, 0);
    for (int i = 0; i < 4; i++)
      check(d[i] === exp[i], "R5 R7 R8 stream byte", d[i], exp[i]);
    recv_byte(1'b1, d[0]);
    check(d[0] === 8'hFF, "R8 silent after nack", d[0], 8'hFF);
    bus_stop();
    read_word(8'h11, 16'h5678, "R5 second register");
  endtask

  task automatic t_lone_byte();
    bit a;
    write_word(8'h90, 8'h20, 16'hAAAA);
    bus_start();
    send_byte(8'h90, a); send_byte(8'h20, a); send_byte(8'h55, a);
    bus_stop();
    read_word(8'h20, 16'hAAAA, "R6 lone byte then stop");
    bus_start();
    send_byte(8'h90, a); send_byte(8'h20, a); send_byte(8'h11, a);
    bus_start();
    send_byte(8'h90, a); send_byte(8'h21, a);
    send_byte(8'h22, a); send_byte(8'h33, a);
    bus_stop();
    read_word(8'h20, 16'hAAAA, "R6 lone byte then start");
    read_word(8'h21, 16'h2233, "R6 R4 pairing restarts");
  endtask

  task automatic t_wrap();
    bit a;
    bus_start();
    send_byte(8'h90, a); send_byte(8'hFF, a);
    send_byte(8'hBE, a); send_byte(8'hEF, a);
    send_byte(8'hCA, a); send_byte(8'hFE, a);
    bus_stop();
    read_word(8'hFF, 16'hBEEF, "R5 last register");
    read_word(8'h00, 16'hCAFE, "R5 wrap to zero");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_addr_select();
    t_write_read();
    t_lone_byte();
    t_wrap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule